// File: doc/BRIEF.md
# SD card bus clock generator

This block derives the clock that drives an SD card bus from a faster kernel clock. It also holds the 32-bit clock-control word that sets up that clock. The word sets the divide ratio, a power-save gate, the bus width, the launch-edge choice, a flow-control gate, double-data-rate signalling, a bus-speed bit and a receive-clock select. The last two are stored and read back for neighbouring logic; this block does not act on them.

Besides the card clock, the block drives a launch strobe. The command and data output stages use it to know when they may change the bus lines. Two inputs stop the card clock at its low level: a bus-idle input (when power-save is on) and a flow-control hold input (when flow control is on). The command and data engines report busy. While either is busy, the control word is frozen and any write attempt sets a sticky error flag. There are no data streams at the edge of this block: every pin is a plain control or status level.

Top module: `sdcard_clkgen`

## Requirements
- R1: After reset, the control word reads 0 and the error flag is 0. The card clock then runs in bypass, equal to the kernel clock.
- R2: The writable bits are divider [9:0], power-save 12, bus width [15:14], edge select 16, flow-control enable 17, DDR 18, bus speed 19 and receive select [21:20]. All other bits read 0 and ignore writes, so writing all ones reads back 0x003FD3FF.
- R3: A write made while the command busy or data busy input is high leaves the word unchanged and sets the error flag. Only reset clears that flag.
- R4: With divider N > 0, the card clock has a period of 2N kernel cycles, high for N and low for N. It changes only just after kernel rising edges.
- R5: With N = 0 (bypass), the card clock follows the kernel clock and the launch strobe stays high, so data changes on every falling card edge. The edge-select bit has no effect.
- R6: With N > 0, SDR and edge select 0, the launch strobe is high for one kernel cycle, starting at the kernel rising edge where the card clock falls.
- R7: With N > 0, SDR and edge select 1, the launch strobe rises at the kernel falling edge that follows a rising card edge and lasts one kernel cycle.
- R8: DDR takes effect only when the bus width is not 00 (1-bit) and N > 0. When it takes effect, the strobe marks both card edges, at the point chosen by edge select. Otherwise the block behaves as SDR.
- R9: With power-save set and bus idle high, the card clock finishes any high phase and then stays low, with no launch strobes. With power-save clear, bus idle has no effect.
- R10: With flow control enabled and the hold input high, the card clock stops low in the same way. Hold has no effect when flow control is disabled. After the hold is released, the first rising card edge comes at the Nth kernel rising edge.
- R11: In bypass mode, a stop request from R9 or R10 holds the card clock low and drops the strobe. The gate changes only while the kernel clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | 32 | Value to write |
| cfg_rd_data | output | 32 | Current control word |
| cfg_wr_err | output | 1 | Sticky flag: a write was refused while busy |
| cmd_busy | input | 1 | Command engine active |
| dat_busy | input | 1 | Data engine active |
| bus_idle | input | 1 | Bus has nothing to transfer |
| fc_hold | input | 1 | Flow-control request to pause the card clock |
| card_clk | output | 1 | Card bus clock |
| launch | output | 1 | Strobe telling the output stages when to change |

## Verification
Some rules are checked by assertions on every kernel rising edge:
- a blocked write leaves the word unchanged and the flag is sticky;
- reserved bits stay zero;
- a stopped clock stays low;
- a high phase does not collapse early;
- every registered launch pulse coincides with a card clock transition.

Other behaviour can only be shown by the bench's scenarios, because it depends on counting whole periods or on the half-cycle strobe:
- exact period and duty for each divider value;
- strobe placement for every edge/DDR combination, including DDR ignored on a 1-bit bus;
- bypass following the kernel clock;
- the restart latency after a hold is released.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  // Field positions are fixed because software decodes them.
  localparam int CFG_W     = 32;
  localparam int PSAVE_BIT = 12;
  localparam int WIDTH_LSB = 14;
  localparam int EDGE_BIT  = 16;
  localparam int FLOW_BIT  = 17;
  localparam int DDR_BIT   = 18;
  localparam int SPEED_BIT = 19;
  localparam int RXSEL_LSB = 20;

  typedef enum logic [1:0] {
    BUS_1B = 2'b00,
    BUS_4B = 2'b01,
    BUS_8B = 2'b10
  } bus_width_e;

  // Bits that hold storage; everything else reads as zero.
  function automatic logic [CFG_W-1:0] writable_mask(input int div_w);
    logic [CFG_W-1:0] m;
    m = '0;
    for (int i = 0; i < div_w; i++) m[i] = 1'b1;
    m[PSAVE_BIT]        = 1'b1;
    m[WIDTH_LSB +: 2]   = 2'b11;
    m[EDGE_BIT]         = 1'b1;
    m[FLOW_BIT]         = 1'b1;
    m[DDR_BIT]          = 1'b1;
    m[SPEED_BIT]        = 1'b1;
    m[RXSEL_LSB +: 2]   = 2'b11;
    return m;
  endfunction
endpackage

// File: rtl/sdclk_cfg_reg.sv
module sdclk_cfg_reg #(
  parameter int DIV_W = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [sdclk_pkg::CFG_W-1:0]  wr_data,
  input  logic                         busy,
  output logic [sdclk_pkg::CFG_W-1:0]  cfg_q,
  output logic                         err_q
);
  localparam logic [sdclk_pkg::CFG_W-1:0] WR_MASK = sdclk_pkg::writable_mask(DIV_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else if (wr_en) begin
      if (busy) err_q <= 1'b1;
      else      cfg_q <= wr_data & WR_MASK;
    end
  end

  // R3: a refused write changes nothing and raises the flag
  p_blocked_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> ($stable(cfg_q) && err_q));

  // R3: the flag only falls through reset
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R2: reserved bits never hold a one
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q & ~WR_MASK) == '0);
endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_n,
  input  logic             run,
  output logic             ck_q,
  output logic             toggle
);
  logic [DIV_W-1:0] cnt;
  logic             bypass;
  logic             active;
  logic             last;

  always_comb begin
    bypass = (div_n == '0);
    // a high phase always completes; a low phase only advances while running
    active = !bypass && (ck_q || run);
    last   = (cnt >= (div_n - 1'b1));
    toggle = active && last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      ck_q <= 1'b0;
    end else if (!active) begin
      cnt <= '0;
      if (bypass) ck_q <= 1'b0;
    end else if (last) begin
      cnt  <= '0;
      ck_q <= ~ck_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R9/R10: a stopped clock stays parked low
  p_stop_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !run && !ck_q) |=> !ck_q);

  // R4: a high phase lasts longer than one kernel cycle when N > 1
  p_high_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ck_q) && div_n > 1 && $stable(div_n)) |=> ck_q);
endmodule

// File: rtl/sdclk_outstage.sv
module sdclk_outstage (
  input  logic clk,
  input  logic rst_n,
  input  logic bypass,
  input  logic run,
  input  logic toggle,
  input  logic ck_q,
  input  logic edge_sel,
  input  logic ddr_eff,
  output logic card_clk,
  output logic launch
);
  logic pulse_q;  // marks a chosen card edge, kernel rising-edge aligned
  logic neg_q;    // same pulse, delayed to the following kernel falling edge
  logic gate_q;   // bypass clock enable, changes only while clk is low

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= toggle && (ddr_eff || (ck_q ^ edge_sel));
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      neg_q  <= pulse_q;
      gate_q <= bypass && run;
    end
  end

  always_comb begin
    card_clk = bypass ? (clk & gate_q) : ck_q;
    if (bypass)        launch = gate_q;
    else if (edge_sel) launch = neg_q;
    else               launch = pulse_q;
  end

  // R6: a registered launch pulse always sits on a card clock transition
  p_launch_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (ck_q != $past(ck_q)));
endmodule

// File: rtl/sdcard_clkgen.sv
module sdcard_clkgen #(
  parameter int DIV_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [31:0] cfg_wr_data,
  output logic [31:0] cfg_rd_data,
  output logic        cfg_wr_err,
  input  logic        cmd_busy,
  input  logic        dat_busy,
  input  logic        bus_idle,
  input  logic        fc_hold,
  output logic        card_clk,
  output logic        launch
);
  import sdclk_pkg::*;

  logic [CFG_W-1:0] cfg_q;
  logic [DIV_W-1:0] div_n;
  logic             psave, edge_sel, flow_en, ddr_req, bypass, run, ddr_eff;
  bus_width_e       width;
  logic             ck_q, toggle;

  sdclk_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .busy(cmd_busy | dat_busy), .cfg_q(cfg_q), .err_q(cfg_wr_err)
  );

  always_comb begin
    div_n    = cfg_q[DIV_W-1:0];
    psave    = cfg_q[PSAVE_BIT];
    width    = bus_width_e'(cfg_q[WIDTH_LSB +: 2]);
    edge_sel = cfg_q[EDGE_BIT];
    flow_en  = cfg_q[FLOW_BIT];
    ddr_req  = cfg_q[DDR_BIT];
    bypass   = (div_n == '0);
    run      = !(psave && bus_idle) && !(flow_en && fc_hold);
    ddr_eff  = ddr_req && (width != BUS_1B) && !bypass;
  end

  sdclk_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div_n(div_n), .run(run),
    .ck_q(ck_q), .toggle(toggle)
  );

  sdclk_outstage u_out (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .run(run), .toggle(toggle),
    .ck_q(ck_q), .edge_sel(edge_sel), .ddr_eff(ddr_eff),
    .card_clk(card_clk), .launch(launch)
  );

  assign cfg_rd_data = cfg_q;

  // R10: with hold honoured, a low divided clock stays low
  p_hold_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && fc_hold && !bypass && !ck_q) |=> !ck_q);
endmodule

// File: tb/sdcard_clkgen_test.sv
module sdcard_clkgen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [31:0] cfg_wr_data;
  logic [31:0] cfg_rd_data;
  logic        cfg_wr_err;
  logic        cmd_busy, dat_busy, bus_idle, fc_hold;
  logic        card_clk, launch;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] MASK = 32'h003F_D3FF;

  always #2 clk = ~clk;  // 250 MHz

  sdcard_clkgen uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .cfg_wr_err(cfg_wr_err), .cmd_busy(cmd_busy),
    .dat_busy(dat_busy), .bus_idle(bus_idle), .fc_hold(fc_hold),
    .card_clk(card_clk), .launch(launch)
  );

  function automatic logic [31:0] mkcfg(int n, bit ps, int w, bit es, bit fe, bit dd);
    logic [31:0] v;
    v        = 32'(n) & 32'h3FF;
    v[12]    = ps;
    v[15:14] = 2'(w);
    v[16]    = es;
    v[17]    = fe;
    v[18]    = dd;
    return v;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    tick();
    cfg_wr_en = 1'b0;
  endtask

  // Observes period, duty and strobe placement against the requirement rules.
  task automatic measure(int n, bit es, bit dd_eff, int cycles, string tag);
    int bad_per = 0, bad_hi = 0, bad_l = 0, rises = 0, since = 0, hi = 0;
    bit seen = 0;
    logic prev, now, ev;
    prev = card_clk;
    for (int i = 0; i < cycles; i++) begin
      tick();
      now = card_clk;
      since++;
      if (prev && !now && seen && hi != n) bad_hi++;
      if (!prev && now) begin
        rises++;
        if (seen && since != 2*n) bad_per++;
        seen = 1; since = 0; hi = 0;
      end
      if (now) hi++;
      ev = dd_eff ? (prev != now) : (es ? (!prev && now) : (prev && !now));
      if (!es && launch !== ev) bad_l++;
      @(negedge clk); #1;
      if (es && launch !== ev) bad_l++;
      prev = now;
    end
    chk(bad_per == 0 && rises >= 2, {tag, " R4 period"}, 32'(bad_per), 0);
    chk(bad_hi == 0, {tag, " R4 high phase"}, 32'(bad_hi), 0);
    chk(bad_l == 0, {tag, " launch placement"}, 32'(bad_l), 0);
  endtask

  task automatic check_parked(int n, string tag);
    int bad = 0;
    repeat (2*n + 2) tick();
    for (int i = 0; i < 3*n + 2; i++) begin
      tick();
      if (card_clk !== 1'b0 || launch !== 1'b0) bad++;
      @(negedge clk); #1;
      if (card_clk !== 1'b0 || launch !== 1'b0) bad++;
    end
    chk(bad == 0, {tag, " parked low"}, 32'(bad), 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int n, w, ticks;
    bit es, dd;
    void'($urandom(32'd2024));
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0;
    cmd_busy = 0; dat_busy = 0; bus_idle = 0; fc_hold = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (2) tick();

    // R1 reset state and bypass clock
    chk(cfg_rd_data == 0, "R1 word after reset", cfg_rd_data, 0);
    chk(cfg_wr_err == 0, "R1 flag after reset", 32'(cfg_wr_err), 0);
    chk(card_clk == 1'b1, "R1 bypass high phase", 32'(card_clk), 1);
    @(negedge clk); #1;
    chk(card_clk == 1'b0, "R1 bypass low phase", 32'(card_clk), 0);

    // R2 reserved bits
    wr(32'hFFFF_FFFF);
    chk(cfg_rd_data == MASK, "R2 all-ones readback", cfg_rd_data, MASK);
    wr(32'h0);

    // R3 blocked writes
    cmd_busy = 1; wr(mkcfg(5, 0, 1, 0, 0, 0)); cmd_busy = 0;
    chk(cfg_rd_data == 0, "R3 write during cmd busy", cfg_rd_data, 0);
    chk(cfg_wr_err == 1, "R3 flag set", 32'(cfg_wr_err), 1);
    dat_busy = 1; wr(mkcfg(7, 0, 0, 0, 0, 0)); dat_busy = 0;
    chk(cfg_rd_data == 0, "R3 write during data busy", cfg_rd_data, 0);
    wr(mkcfg(3, 0, 0, 0, 0, 0));
    chk(cfg_rd_data == mkcfg(3, 0, 0, 0, 0, 0), "R3 idle write accepted", cfg_rd_data, mkcfg(3, 0, 0, 0, 0, 0));
    chk(cfg_wr_err == 1, "R3 flag sticky", 32'(cfg_wr_err), 1);

    // R4 + R6 divided SDR, edge 0
    repeat (3) tick();
    measure(3, 0, 0, 40, "R6 N3 edge0");
    // R7 edge 1
    wr(mkcfg(4, 0, 0, 1, 0, 0)); repeat (3) tick();
    measure(4, 1, 0, 50, "R7 N4 edge1");
    // R8 DDR effective and ignored on a 1-bit bus
    wr(mkcfg(2, 0, 1, 0, 0, 1)); repeat (3) tick();
    measure(2, 0, 1, 30, "R8 DDR edge0");
    wr(mkcfg(2, 0, 2, 1, 0, 1)); repeat (3) tick();
    measure(2, 1, 1, 30, "R8 DDR edge1");
    wr(mkcfg(3, 0, 0, 0, 0, 1)); repeat (3) tick();
    measure(3, 0, 0, 40, "R8 DDR on 1-bit bus");
    wr(mkcfg(1, 0, 0, 0, 0, 0)); repeat (3) tick();
    measure(1, 0, 0, 20, "R4 N1");

    // R5 bypass ignores edge select and DDR
    wr(mkcfg(0, 0, 1, 1, 0, 1)); repeat (2) tick();
    chk(card_clk == 1 && launch == 1, "R5 bypass high, strobe", {30'd0, card_clk, launch}, 3);
    @(negedge clk); #1;
    chk(card_clk == 0 && launch == 1, "R5 bypass low, strobe", {30'd0, card_clk, launch}, 1);

    // R11 bypass gated by power save
    wr(mkcfg(0, 1, 0, 0, 0, 0)); bus_idle = 1; repeat (2) tick();
    chk(card_clk == 0 && launch == 0, "R11 bypass gated", {30'd0, card_clk, launch}, 0);
    bus_idle = 0; repeat (2) tick();
    chk(card_clk == 1, "R11 bypass resumes", 32'(card_clk), 1);

    // R9 power save in divided mode
    wr(mkcfg(3, 1, 0, 0, 0, 0)); repeat (3) tick();
    bus_idle = 1;
    check_parked(3, "R9 power save");
    bus_idle = 0;
    wr(mkcfg(3, 0, 0, 0, 0, 0)); bus_idle = 1; repeat (3) tick();
    measure(3, 0, 0, 30, "R9 idle without power save");
    bus_idle = 0;

    // R10 flow-control hold and restart latency
    wr(mkcfg(4, 0, 0, 0, 1, 0)); repeat (3) tick();
    fc_hold = 1;
    check_parked(4, "R10 hold");
    fc_hold = 0; ticks = 0;
    do begin tick(); ticks++; end while (card_clk == 0 && ticks < 50);
    chk(ticks == 4, "R10 restart latency", 32'(ticks), 4);
    wr(mkcfg(4, 0, 0, 0, 0, 0)); fc_hold = 1; repeat (3) tick();
    measure(4, 0, 0, 40, "R10 hold without flow control");
    fc_hold = 0;

    // Random mix of divider, width, edge and DDR
    for (int k = 0; k < 10; k++) begin
      n  = 1 + int'($urandom % 8);
      w  = int'($urandom % 3);
      es = 1'($urandom);
      dd = 1'($urandom);
      wr(mkcfg(n, 0, w, es, 0, dd)); repeat (3) tick();
      measure(n, es, dd && (w != 0), 8*n + 6, $sformatf("R8 random%0d", k));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule